// File: doc/BRIEF.md
# SD card SPI command engine

This block is the host side of a memory card link running in SPI mode 0. A single start pulse hands it a 6-bit command index, a 32-bit argument and a response kind. It then pulls chip select low and clocks 0xFF until the card answers 0xFF, which shows the card is ready. Next it shifts out a six-byte command frame, and after that it keeps sending 0xFF while it watches for a response byte whose top bit is clear. Depending on the response kind, it then reads four more payload bytes or waits for the card to leave its busy state. At the end it raises chip select and pulses `done`.

The serial clock is the system clock divided by a parameter. Each of the three waits has its own limit: ready bytes, response bytes and busy cycles. When any limit runs out, the transaction ends with `timeout` set. The results stay on the outputs until the next start.

Top module: `sd_spi_cmd`

## Requirements
- R1: Bytes go out MSB first in SPI mode 0. `sclk` idles low, `mosi` changes only while `sclk` is low, and `miso` is sampled when `sclk` rises. One byte takes 16*DIV system clocks.
- R2: `cs_n` falls only in the cycle after `start` is accepted and stays low until the transaction ends. `sclk` is never high while `cs_n` is high.
- R3: Before the frame the engine sends 0xFF bytes until a received byte equals 0xFF. If READY_MAX such bytes pass without one, it ends with `timeout`=1 and no frame is sent.
- R4: The frame is six bytes, in this order: {2'b01, index}, then the argument MSB byte first, then a check byte. The check byte is 0x95 for index 0, 0x87 for index 8, and 0x01 for every other index.
- R5: After the frame the engine sends 0xFF bytes and accepts the first received byte with bit 7 = 0 as the status byte. That byte may arrive in any of the first RESP_WIN+1 poll bytes (default 9, meaning 0 to 8 bytes of delay). If none arrives in that window, `timeout`=1 and `r1` stays 0xFF.
- R6: `r1` holds the accepted status byte. `error` is 1 exactly when that byte is nonzero.
- R7: For rsp_kind 2 (R3) and 3 (R7), four more 0xFF bytes are sent, and the bytes received meanwhile form `payload`, first byte in bits 31:24.
- R8: For rsp_kind 1 (R1b), the engine keeps sending 0xFF after the status byte until a received byte equals 0xFF. If this lasts BUSY_LIMIT system clocks, it ends with `timeout`=1. rsp_kind 0 (R1) ends right after the status byte.
- R9: `done` is a one-cycle pulse that comes together with `cs_n` rising. `r1`, `payload`, `timeout` and `error` hold their values from then until the next `start`. After reset `cs_n`=1, `sclk`=0, `mosi`=1 and `r1`=0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 R1, 1 R1b, 2 R3, 3 R7 |
| miso | input | 1 | Serial data from card |
| cs_n | output | 1 | Card chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to card |
| done | output | 1 | End-of-command pulse |
| r1 | output | 8 | Status byte |
| payload | output | 32 | Trailing 32-bit response |
| timeout | output | 1 | A wait limit expired |
| error | output | 1 | Status byte nonzero |

## Verification
Chip select falls one cycle after `start` is sampled, and each byte then takes 16*DIV clocks. The bench therefore captures every MOSI byte at its eighth rising `sclk` edge and compares it with a byte list that a behavioural model builds from the scripted card replies. Status, payload and flags are due in the cycle in which `done` is first high. They are compared there and again one cycle later, when `done` must be low and the values unchanged. On every clock the chip-select and `sclk` levels are checked against the model's idea of whether a transaction is open.

// File: rtl/sd_spi_cmd.sv
`timescale 1ns/1ps
module sd_spi_cmd #(
  parameter int DIV        = 4,
  parameter int READY_MAX  = 64,
  parameter int RESP_WIN   = 8,
  parameter int BUSY_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  rsp_kind,
  input  logic        miso,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  output logic        done,
  output logic [7:0]  r1,
  output logic [31:0] payload,
  output logic        timeout,
  output logic        error
);
  localparam int DW = $clog2(DIV + 1);
  localparam int NW = $clog2(READY_MAX + RESP_WIN + 8);
  localparam int BW = $clog2(BUSY_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_FRAME, S_POLL, S_DATA, S_BUSY, S_END} st_t;

  st_t            st;
  logic [7:0]     tx, rx;
  logic [2:0]     bitn;
  logic [DW-1:0]  dcnt;
  logic [NW-1:0]  nb;
  logic [BW-1:0]  bcnt;
  logic [1:0]     kind;
  logic [47:0]    frame;

  wire [7:0] chk  = (cmd_idx == 6'd0) ? 8'h95 : (cmd_idx == 6'd8) ? 8'h87 : 8'h01;
  wire       tick = (dcnt == DW'(DIV - 1));

  assign mosi = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tx <= 8'hFF; rx <= 8'h00; bitn <= '0; dcnt <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; done <= 1'b0; nb <= '0; bcnt <= '0;
      kind <= '0; frame <= '0; r1 <= 8'hFF; payload <= '0;
      timeout <= 1'b0; error <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cs_n <= 1'b0; frame <= {2'b01, cmd_idx, cmd_arg, chk}; kind <= rsp_kind;
          tx <= 8'hFF; bitn <= '0; dcnt <= '0; sclk <= 1'b0; nb <= '0;
          r1 <= 8'hFF; payload <= '0; timeout <= 1'b0; error <= 1'b0;
          st <= S_READY;
        end
        S_END: begin
          cs_n <= 1'b1; sclk <= 1'b0; tx <= 8'hFF; done <= 1'b1; st <= S_IDLE;
        end
        default: begin
          if (st == S_BUSY) bcnt <= bcnt + 1'b1;
          if (!tick) dcnt <= dcnt + 1'b1;
          else begin
            dcnt <= '0;
            sclk <= ~sclk;
            if (!sclk) rx <= {rx[6:0], miso};
            else if (bitn != 3'd7) begin
              bitn <= bitn + 1'b1;
              tx   <= {tx[6:0], 1'b1};
            end else begin
              bitn <= '0; tx <= 8'hFF; nb <= nb + 1'b1;
              case (st)
                S_READY:
                  if (rx == 8'hFF) begin
                    st <= S_FRAME; tx <= frame[47:40]; frame <= frame << 8; nb <= '0;
                  end else if (nb == NW'(READY_MAX - 1)) begin
                    timeout <= 1'b1; st <= S_END;
                  end
                S_FRAME:
                  if (nb == NW'(5)) begin
                    st <= S_POLL; nb <= '0;
                  end else begin
                    tx <= frame[47:40]; frame <= frame << 8;
                  end
                S_POLL:
                  if (!rx[7]) begin
                    r1 <= rx; error <= (rx != 8'h00); nb <= '0; bcnt <= '0;
                    st <= (kind == 2'd1) ? S_BUSY : (kind[1] ? S_DATA : S_END);
                  end else if (nb == NW'(RESP_WIN)) begin
                    timeout <= 1'b1; st <= S_END;
                  end
                S_DATA: begin
                  payload <= {payload[23:0], rx};
                  if (nb == NW'(3)) st <= S_END;
                end
                S_BUSY: if (rx == 8'hFF) st <= S_END;
                default: ;
              endcase
            end
          end
          if (st == S_BUSY && bcnt == BW'(BUSY_LIMIT)) begin
            timeout <= 1'b1; st <= S_END;
          end
        end
      endcase
    end
  end

  p_mosi_low_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);
  p_sclk_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  p_cs_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start));
  p_timeout_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |=> done);
  p_error_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (error == (r1 != 8'h00 && !r1[7])));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> ($stable(r1) && $stable(payload) && $stable(timeout)));
endmodule

// File: tb/sd_spi_cmd_test.sv
`timescale 1ns/1ps
module sd_spi_cmd_test;
  localparam int DIV = 2;
  localparam int RDY = 16;
  localparam int BLIM = 400;
  localparam int BYTE_CYC = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] idx = '0;
  logic [31:0] arg = '0;
  logic [1:0] kind = '0;
  logic miso = 1'b1;
  wire cs_n, sclk, mosi, done, timeout, error;
  wire [7:0] r1;
  wire [31:0] payload;

  always #2 clk = ~clk;

  sd_spi_cmd #(.DIV(DIV), .READY_MAX(RDY), .RESP_WIN(8), .BUSY_LIMIT(BLIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(idx), .cmd_arg(arg),
    .rsp_kind(kind), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .done(done), .r1(r1), .payload(payload), .timeout(timeout), .error(error));

  int total = 0, bad = 0;
  logic [7:0] cq[$];
  logic [7:0] got[$];
  logic [7:0] expb[$];
  string etag[$];
  logic [7:0] e_r1;
  logic [31:0] e_pay;
  bit e_to, e_err, e_part, in_txn = 0;

  int bidx = 0, ptr = 0, bitc = 0;
  logic [7:0] sh = '0;
  always @(sclk or cs_n) begin
    if (cs_n) begin
      bidx = 0; ptr = 0; bitc = 0;
    end else if (sclk) begin
      sh = {sh[6:0], mosi};
      bitc++;
      if (bitc == 8) got.push_back(sh);
    end else if (bitc == 8) begin
      bitc = 0; ptr = 0; bidx++;
    end else if (bitc > 0) ptr = bitc;
    miso = cs_n ? 1'b1 : ((bidx < cq.size()) ? cq[bidx][3'(7 - ptr)] : 1'b1);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    total++;
    if ((sclk && cs_n) || (in_txn && cs_n && !done)) begin
      bad++;
      $display("FAIL R2 framing: cs_n=%b sclk=%b expected cs_n=%b", cs_n, sclk, !in_txn);
    end
  end

  task automatic card(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) cq.push_back(b);
  endtask

  task automatic predict(logic [1:0] k, logic [5:0] id, logic [31:0] a);
    int p = 0, cnt = 0;
    logic [7:0] b = 8'hFF, c;
    bit ok = 0;
    expb.delete(); etag.delete();
    e_r1 = 8'hFF; e_pay = '0; e_to = 0; e_err = 0; e_part = 0;
    for (int n = 0; n < RDY; n++) begin
      expb.push_back(8'hFF); etag.push_back("R3");
      b = (p < cq.size()) ? cq[p] : 8'hFF; p++;
      if (b == 8'hFF) begin ok = 1; break; end
    end
    if (!ok) begin e_to = 1; return; end
    c = (id == 6'd0) ? 8'h95 : (id == 6'd8) ? 8'h87 : 8'h01;
    expb.push_back({2'b01, id}); expb.push_back(a[31:24]); expb.push_back(a[23:16]);
    expb.push_back(a[15:8]); expb.push_back(a[7:0]); expb.push_back(c);
    for (int i = 0; i < 6; i++) etag.push_back("R4");
    p += 6;
    ok = 0;
    for (int n = 0; n <= 8; n++) begin
      expb.push_back(8'hFF); etag.push_back("R5");
      b = (p < cq.size()) ? cq[p] : 8'hFF; p++;
      if (!b[7]) begin ok = 1; break; end
    end
    if (!ok) begin e_to = 1; return; end
    e_r1 = b; e_err = (b != 8'h00);
    if (k[1]) begin
      for (int i = 0; i < 4; i++) begin
        expb.push_back(8'hFF); etag.push_back("R7");
        b = (p < cq.size()) ? cq[p] : 8'hFF; p++;
        e_pay = {e_pay[23:0], b};
      end
    end else if (k == 2'd1) begin
      for (int n = 0; n < 64; n++) begin
        expb.push_back(8'hFF); etag.push_back("R8");
        b = (p < cq.size()) ? cq[p] : 8'hFF; p++; cnt++;
        if (b == 8'hFF) break;
      end
      if (cnt * BYTE_CYC > BLIM) begin e_to = 1; e_part = 1; end
    end
  endtask

  task automatic run(string name, logic [1:0] k, logic [5:0] id, logic [31:0] a);
    int g0, cyc = 0, n;
    predict(k, id, a);
    g0 = got.size();
    @(negedge clk); idx = id; arg = a; kind = k; start = 1'b1;
    @(negedge clk); start = 1'b0; in_txn = 1;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    in_txn = 0;
    chk({"R9 done seen ", name}, done, 1);
    chk({"R6 r1 ", name}, r1, e_r1);
    chk({"R6 error ", name}, error, e_err);
    chk({"R5/R8 timeout ", name}, timeout, e_to);
    chk({"R7 payload ", name}, payload, e_pay);
    n = got.size() - g0;
    if (!e_part) chk({"R1 byte count ", name}, n, expb.size());
    for (int i = 0; i < n && i < expb.size(); i++)
      chk({etag[i], " mosi byte ", name}, got[g0 + i], expb[i]);
    @(negedge clk);
    chk({"R9 done pulse ", name}, done, 0);
    chk({"R9 r1 held ", name}, r1, e_r1);
    chk({"R9 cs released ", name}, cs_n, 1);
    cq.delete();
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset cs_n", cs_n, 1);
    chk("R9 reset sclk", sclk, 0);
    chk("R9 reset mosi", mosi, 1);
    chk("R9 reset done", done, 0);
    chk("R9 reset r1", r1, 8'hFF);

    card(8'hFF, 8); card(8'h01, 1);
    run("r1 idx0", 2'd0, 6'd0, 32'h0);

    card(8'h00, 2); card(8'hFF, 7); card(8'h00, 2); card(8'h01, 1); card(8'hAA, 1);
    run("r7 idx8", 2'd3, 6'd8, 32'h000001AA);

    card(8'hFF, 15); card(8'h00, 1); card(8'hC0, 1); card(8'hFF, 1); card(8'h80, 1); card(8'h00, 1);
    run("r3 late edge", 2'd2, 6'd58, 32'h0);

    card(8'hFF, 16); card(8'h00, 1);
    run("r1 poll timeout", 2'd0, 6'd17, 32'hDEADBEEF);

    card(8'hFF, 7); card(8'h00, 4); card(8'hFF, 1);
    run("r1b short busy", 2'd1, 6'd12, 32'h12345678);

    card(8'hFF, 7); card(8'h00, 41);
    run("r1b busy timeout", 2'd1, 6'd38, 32'h0);

    card(8'h00, 20);
    run("ready timeout", 2'd0, 6'd1, 32'h0);

    card(8'hFF, 9); card(8'h04, 1);
    run("r1 error", 2'd0, 6'd55, 32'hA5A5_0F0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule